// File: doc/BRIEF.md
# PCM Output Conditioner with Mute and Pad

This block sits between a speech decoder and the serialiser that drives the PCM line. It takes each 8-bit companded word the decoder produces and conditions it before it goes out. When conditioning is enabled, one of two actions is applied, chosen by a mode input. In mute mode the word is replaced by the silent code of the active companding law. In pad mode the word is attenuated by 12 dB without expanding it to linear form. A through-mode flag overrides both actions and lets the byte pass untouched.

Attenuation works on the segment/mantissa form of the code. The line inversion of the selected law is removed, the segment number is lowered by two, and the inversion is applied again. Codes in the two lowest segments cannot move down two segments. They are instead scaled within segment 0, rounding toward zero. Every accepted word appears on the output one clock later with a valid strobe. A two-state machine controls the strobe. ST_IDLE moves to ST_EMIT when a word is accepted. ST_EMIT stays in ST_EMIT on a back-to-back word and returns to ST_IDLE when no word arrives.

Top module: `pcm_out_conditioner`

## Requirements
- R1: While reset is low, and in the first cycle after it, out_valid is 0 and out_code is 8'h00.
- R2: A word with in_valid high appears on out_code with out_valid high exactly one clock later. out_valid is low in any cycle that follows a clock with in_valid low, and out_code keeps its last value through such gaps.
- R3: With thru_en=0 and cond_en=0, out_code equals in_code whatever law_a and pad_sel are.
- R4: With thru_en=0, cond_en=1, pad_sel=0 (mute) and law_a=1 (A-law), out_code is 8'hD5 for every input code.
- R5: With thru_en=0, cond_en=1, pad_sel=0 (mute) and law_a=0 (µ-law), out_code is 8'hFF for every input code.
- R6: Pad is active when thru_en=0, cond_en=1 and pad_sel=1. Let u = in_code XOR mask, where the mask is 8'h55 for A-law and 8'hFF for µ-law. Bit 7 of u is the sign, bits 6:4 the segment and bits 3:0 the mantissa. If the segment is 2 or more, the result keeps the sign and mantissa and has the segment minus 2. out_code is the result XOR the same mask, so bit 7 of out_code equals bit 7 of in_code.
- R7: In pad mode, a segment of 0 or 1 gives segment 0 with mantissa equal to {segment bit 0, mantissa} shifted right by 2. The sign is kept and the same mask is applied.
- R8: With thru_en=1, out_code equals in_code for every combination of cond_en, pad_sel and law_a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded word strobe |
| in_code | input | 8 | Decoded companded word |
| law_a | input | 1 | 1 selects A-law, 0 selects µ-law |
| pad_sel | input | 1 | 1 selects pad, 0 selects mute |
| cond_en | input | 1 | Channel mute/pad enable |
| thru_en | input | 1 | Through mode, overrides conditioning |
| out_valid | output | 1 | Conditioned word strobe |
| out_code | output | 8 | Conditioned companded word |

## Verification
The bench sweeps all 256 codes through pad mode under both laws.

- A design that used one inversion mask for both laws, or dropped the mask, would give wrong segments for half the sweep.
- A design that wrapped the segment below zero would turn the quietest codes into loud ones, which the segment 0/1 cases catch.
- Through mode is tried with the enable high in both modes, so an override with the wrong priority gives idle or attenuated bytes.
- Gaps between words expose a strobe that stays high, and also expose a data register that keeps loading when no word is presented.

// File: rtl/pcm_cond_pkg.sv
package pcm_cond_pkg;
    localparam int SEG_W  = 3;
    localparam int MANT_W = 4;
    localparam int CODE_W = 1 + SEG_W + MANT_W;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_MUTE = 2'd1,
        MODE_PAD  = 2'd2
    } cond_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;
endpackage

// File: rtl/pcm_line_inv.sv
module pcm_line_inv #(
    parameter int CODE_W = 8
) (
    input  logic              law_a,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o
);
    // A-law toggles the even bits, mu-law toggles every bit
    for (genvar i = 0; i < CODE_W; i++) begin : g_bit
        localparam logic EVEN_BIT = ((i % 2) == 0);
        assign code_o[i] = code_i[i] ^ (~law_a | EVEN_BIT);
    end
endmodule

// File: rtl/pcm_pad_atten.sv
module pcm_pad_atten #(
    parameter int SEG_W     = 3,
    parameter int MANT_W    = 4,
    parameter int PAD_STEPS = 2
) (
    input  logic [SEG_W+MANT_W:0] lin_i,
    output logic [SEG_W+MANT_W:0] lin_o
);
    localparam int CODE_W = 1 + SEG_W + MANT_W;
    localparam int IDX_W  = SEG_W + MANT_W;

    logic              sign;
    logic [SEG_W-1:0]  seg;
    logic [MANT_W-1:0] mant;

    assign sign = lin_i[CODE_W-1];
    assign seg  = lin_i[CODE_W-2 -: SEG_W];
    assign mant = lin_i[MANT_W-1:0];

    if (PAD_STEPS == 0) begin : g_none
        assign lin_o = lin_i;
    end else begin : g_shift
        logic [IDX_W-1:0]  low_idx;
        logic [SEG_W-1:0]  seg_o;
        logic [MANT_W-1:0] mant_o;

        assign low_idx = {seg, mant} >> PAD_STEPS;

        always_comb begin
            if (seg >= SEG_W'(PAD_STEPS)) begin
                seg_o  = seg - SEG_W'(PAD_STEPS);
                mant_o = mant;
            end else begin
                seg_o  = '0;
                mant_o = low_idx[MANT_W-1:0];
            end
        end

        assign lin_o = {sign, seg_o, mant_o};
    end
endmodule

// File: rtl/pcm_mode_pick.sv
module pcm_mode_pick
    import pcm_cond_pkg::*;
(
    input  logic       thru_en,
    input  logic       cond_en,
    input  logic       pad_sel,
    output cond_mode_e mode
);
    always_comb begin
        if (thru_en || !cond_en) begin
            mode = MODE_PASS;
        end else if (pad_sel) begin
            mode = MODE_PAD;
        end else begin
            mode = MODE_MUTE;
        end
    end
endmodule

// File: rtl/pcm_out_conditioner.sv
module pcm_out_conditioner
    import pcm_cond_pkg::*;
#(
    parameter int              PAD_STEPS = 2,
    parameter logic [CODE_W-1:0] IDLE_A  = 8'hD5,
    parameter logic [CODE_W-1:0] IDLE_U  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    input  logic              law_a,
    input  logic              pad_sel,
    input  logic              cond_en,
    input  logic              thru_en,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);
    cond_mode_e        mode;
    out_state_e        state_q, state_d;
    logic [CODE_W-1:0] lin_code, lin_att, pad_code, idle_code, next_code;
    logic [CODE_W-1:0] code_q;

    pcm_mode_pick u_pick (
        .thru_en (thru_en),
        .cond_en (cond_en),
        .pad_sel (pad_sel),
        .mode    (mode)
    );

    pcm_line_inv #(.CODE_W(CODE_W)) u_unmask (
        .law_a  (law_a),
        .code_i (in_code),
        .code_o (lin_code)
    );

    pcm_pad_atten #(
        .SEG_W     (SEG_W),
        .MANT_W    (MANT_W),
        .PAD_STEPS (PAD_STEPS)
    ) u_atten (
        .lin_i (lin_code),
        .lin_o (lin_att)
    );

    pcm_line_inv #(.CODE_W(CODE_W)) u_remask (
        .law_a  (law_a),
        .code_i (lin_att),
        .code_o (pad_code)
    );

    assign idle_code = law_a ? IDLE_A : IDLE_U;

    always_comb begin
        next_code = in_code;
        unique case (mode)
            MODE_PASS: next_code = in_code;
            MODE_MUTE: next_code = idle_code;
            MODE_PAD:  next_code = pad_code;
            default:   next_code = in_code;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // data register loads only on accepted words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (in_valid) begin
            code_q <= next_code;
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_EMIT);
        out_code  = code_q;
    end
endmodule

// File: rtl/pcm_out_conditioner_chk.sv
module pcm_out_conditioner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_code,
    input logic       law_a,
    input logic       pad_sel,
    input logic       cond_en,
    input logic       thru_en,
    input logic       out_valid,
    input logic [7:0] out_code
);
    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_strobe_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_in_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code));

    p_pass_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !thru_en && !cond_en) |=> (out_code == $past(in_code)));

    p_mute_alaw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !thru_en && cond_en && !pad_sel && law_a) |=> (out_code == 8'hD5));

    p_mute_ulaw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !thru_en && cond_en && !pad_sel && !law_a) |=> (out_code == 8'hFF));

    p_pad_keeps_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !thru_en && cond_en && pad_sel) |=> (out_code[7] == $past(in_code[7])));

    p_thru_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && thru_en) |=> (out_code == $past(in_code)));
endmodule

bind pcm_out_conditioner pcm_out_conditioner_chk u_chk (.*);

// File: tb/pcm_out_conditioner_tb.sv
`timescale 1ns/1ps
module pcm_out_conditioner_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_code = 8'h00;
    logic       law_a = 1'b0;
    logic       pad_sel = 1'b0;
    logic       cond_en = 1'b0;
    logic       thru_en = 1'b0;
    logic       out_valid;
    logic [7:0] out_code;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic [7:0]  last_exp = 8'h00;

    always #2.5 clk = ~clk;

    pcm_out_conditioner u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .law_a     (law_a),
        .pad_sel   (pad_sel),
        .cond_en   (cond_en),
        .thru_en   (thru_en),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    function automatic logic [7:0] model(input logic [7:0] c, input logic la,
                                         input logic pd, input logic en, input logic th);
        logic [7:0] m, u, r;
        logic [2:0] sg;
        logic [3:0] mn;
        logic [4:0] idx;
        if (th || !en) return c;
        if (!pd) return la ? 8'hD5 : 8'hFF;
        m  = la ? 8'h55 : 8'hFF;
        u  = c ^ m;
        sg = u[6:4];
        mn = u[3:0];
        if (sg >= 3'd2) begin
            r = {u[7], sg - 3'd2, mn};
        end else begin
            idx = {sg[0], mn} >> 2;
            r = {u[7], 3'd0, idx[3:0]};
        end
        return r ^ m;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic la, input logic pd,
                        input logic en, input logic th, input string tag);
        in_code  = c;
        law_a    = la;
        pad_sel  = pd;
        cond_en  = en;
        thru_en  = th;
        in_valid = 1'b1;
        last_exp = model(c, la, pd, en, th);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        in_valid = 1'b0;
        in_code  = ~in_code;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected strobe", 8'h01, 8'h00);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, out_code, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog expired: got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset valid", {7'd0, out_valid}, 8'h00);
        check("R1 reset code", out_code, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset valid", {7'd0, out_valid}, 8'h00);
        check("R1 post-reset code", out_code, 8'h00);

        // R3: disabled, every law and mode
        for (int k = 0; k < 8; k++) begin
            send(8'(k * 37 + 5), k[0], k[1], 1'b0, 1'b0, "R3 pass");
        end
        gap(3);
        check("R2 gap valid low", {7'd0, out_valid}, 8'h00);
        check("R2 gap code held", out_code, last_exp);

        // R4 / R5 mute
        for (int k = 0; k < 6; k++) begin
            send(8'(k * 51 + 3), 1'b1, 1'b0, 1'b1, 1'b0, "R4 mute A");
            send(8'(k * 29 + 1), 1'b0, 1'b0, 1'b1, 1'b0, "R5 mute u");
        end
        gap(1);

        // R6 / R7 pad sweep, both laws, alternating gaps
        for (int la = 0; la < 2; la++) begin
            for (int c = 0; c < 256; c++) begin
                logic [7:0] u;
                u = 8'(c) ^ (la == 1 ? 8'h55 : 8'hFF);
                if (u[6:4] >= 3'd2) send(8'(c), la[0], 1'b1, 1'b1, 1'b0, "R6 pad upper");
                else                send(8'(c), la[0], 1'b1, 1'b1, 1'b0, "R7 pad low");
                if ((c % 17) == 0) gap(2);
            end
        end
        gap(2);
        check("R2 hold after pad", out_code, last_exp);

        // R8 through overrides everything
        for (int k = 0; k < 16; k++) begin
            send(8'(k * 13 + 7), k[0], k[1], k[2] | k[3], 1'b1, "R8 thru");
        end
        // mode switch between neighbours
        send(8'h2A, 1'b1, 1'b1, 1'b1, 1'b1, "R8 thru pad");
        send(8'h2A, 1'b1, 1'b1, 1'b1, 1'b0, "R6 pad after thru");
        send(8'h2A, 1'b0, 1'b0, 1'b1, 1'b0, "R5 mute after pad");
        gap(4);
        check("R2 final valid low", {7'd0, out_valid}, 8'h00);
        check("R2 final hold", out_code, last_exp);
        check("R2 queue drained", 8'(exp_q.size()), 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule